// File: doc/BRIEF.md
# DRAM Refresh Controller

This block connects a simple processor-style memory request port to an asynchronous-strobe DRAM. The DRAM has a narrow multiplexed address bus, an active-low row strobe, an active-low column strobe and an active-low write enable. A processor request carries a 16-bit word address. The controller splits that address into two 8-bit halves. The low half is the row: it goes onto the shared bus first and is taken in when the row strobe falls. The high half is the column: it follows on the same pins and is taken in when the column strobe falls. The column strobe also selects the device, so data moves only while it is low.

An internal interval timer requests a refresh once per interval. By default the interval is 3125 cycles at 200 MHz, which covers all 256 rows in 4 ms. A refresh is a row-strobe-only cycle. Its row comes from a refresh row counter, and that counter advances by one when each refresh cycle ends. The processor holds its request and sees `req_ready` low until the access has been served. A refresh that is pending wins over a request that has not yet started. An access that is already under way always finishes first. Both strobes stay high for a set precharge time between cycles. If a refresh request is still unserved when the next interval ends, a sticky overrun flag is raised.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: When reset ends, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1. `req_ready`, `dram_dq_oe` and `refresh_overrun` are 0.
- R2: For an access, `dram_addr` holds `req_addr[7:0]` (the row) for at least one cycle before `dram_ras_n` falls and in the cycle where it falls. `dram_addr` changes to `req_addr[15:8]` (the column) only after `dram_ras_n` is low. `dram_cas_n` never falls in the same cycle as `dram_ras_n`.
- R3: `dram_cas_n` is low only while `dram_ras_n` is low. On a write (`req_write`=1), `dram_we_n` is 0 and `dram_dq_oe` is 1 while the column strobe is low, with `dram_dq_out` = `req_wdata`. On a read, `req_rdata` returns the `dram_dq_in` value that was present while the column strobe was low.
- R4: In a refresh cycle, `dram_ras_n` goes low and `dram_cas_n` stays high throughout. The row on `dram_addr` is the refresh row counter. That counter is 0 after reset and goes up by 1, modulo 256, when each refresh cycle ends.
- R5: A refresh request is raised REF_INTERVAL cycles after reset ends, and every REF_INTERVAL cycles after that. If the controller is idle, `dram_ras_n` falls 2 cycles after the request is raised.
- R6: When a refresh request and a processor request both wait in the idle state, the refresh cycle runs first. An access that has already left idle completes without any refresh cycle in the middle of it.
- R7: `req_ready` stays 0 until the access is served, then is 1 for exactly one cycle. From an idle start, `req_ready` rises 2+T_RCD+T_CAS cycles after the request is first seen.
- R8: Between the end of one row-strobe-low period and the start of the next, both strobes are high for at least T_RP cycles.
- R9: A refresh request that is not served stays pending. If the interval ends again while a request is still pending, `refresh_overrun` is set and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_W | Word address: low half row, high half column |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-cycle pulse when the access is served |
| req_rdata | output | DATA_W | Read data, valid with `req_ready` |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe / device select, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Read data from the DRAM |
| refresh_overrun | output | 1 | Sticky: a refresh interval was missed |

## Verification
A refresh row counter in the wrong state shows up at the next row-strobe-only cycle: the row on the bus breaks the 0, 1, 2 sequence, which is visible within one interval. A swapped or stale address half shows as wrong row or column values at the strobe edges during the same access. It also shows as read data that comes back from a different location. A fault in the interval timer or the pending flag moves the refresh start away from its exact expected cycle, or lets an overrun appear. A sequencer stuck in a state shows as a `req_ready` that is late or missing, within a few cycles of the request.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ROW   = 3'd2,
    ST_COL   = 3'd3,
    ST_REF   = 3'd4,
    ST_PRE   = 3'd5
  } seq_state_t;

  // bits needed to hold a down-counter loaded with (largest phase - 1)
  function automatic int phase_cnt_width(input int a, input int b,
                                         input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/drc_refresh_timer.sv
module drc_refresh_timer #(
  parameter int REF_INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  output logic pending,
  output logic overrun
);
  localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [IW-1:0] ivl_cnt;
  logic          wrap;

  assign wrap = (ivl_cnt == IW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_cnt <= '0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ivl_cnt <= wrap ? '0 : ivl_cnt + 1'b1;
      if (wrap) begin
        if (pending && !grant) overrun <= 1'b1;
        pending <= 1'b1;
      end else if (grant) begin
        pending <= 1'b0;
      end
    end
  end

  // R9: an unserved request stays pending
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (rst)
    (pending && !grant) |=> pending);

  // R9: overrun is sticky
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

// File: rtl/drc_row_counter.sv
module drc_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (inc) row <= row + 1'b1;
  end

  // R4: the counter only moves when a refresh cycle ends
  assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(row));

endmodule

// File: rtl/drc_addr_mux.sv
module drc_addr_mux #(
  parameter int ROW_W = 8
) (
  input  logic [2*ROW_W-1:0] word_addr,
  input  logic [ROW_W-1:0]   refresh_row,
  input  logic               use_refresh,
  input  logic               col_phase,
  output logic [ROW_W-1:0]   bus_addr
);
  logic [ROW_W-1:0] row_half;
  logic [ROW_W-1:0] col_half;

  assign row_half = word_addr[ROW_W-1:0];
  assign col_half = word_addr[2*ROW_W-1:ROW_W];

  always_comb begin
    if (use_refresh)    bus_addr = refresh_row;
    else if (col_phase) bus_addr = col_half;
    else                bus_addr = row_half;
  end
endmodule

// File: rtl/drc_sequencer.sv
module drc_sequencer
  import drc_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 3,
  parameter int T_RP   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2*ROW_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 ref_pending,
  input  logic [ROW_W-1:0]     ref_row,
  output logic                 ref_grant,
  output logic                 row_inc,
  output logic                 req_ready,
  output logic [DATA_W-1:0]    req_rdata,
  output logic [ROW_W-1:0]     dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic [DATA_W-1:0]    dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_W-1:0]    dram_dq_in
);
  localparam int CW = phase_cnt_width(T_RCD, T_CAS, T_RAS, T_RP);
  localparam int AW = 2 * ROW_W;
  localparam int HW = (T_RP < 2) ? 1 : $clog2(T_RP + 1);

  seq_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [AW-1:0]     op_addr_q, op_addr_d;
  logic              op_wr_q, op_wr_d;
  logic              op_ref_q, op_ref_d;
  logic [DATA_W-1:0] op_data_q, op_data_d;
  logic              done;
  logic              col_phase;
  logic              strobe_row;
  logic              write_col;
  logic [ROW_W-1:0]  mux_addr;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    op_addr_d = op_addr_q;
    op_wr_d   = op_wr_q;
    op_ref_d  = op_ref_q;
    op_data_d = op_data_q;
    ref_grant = 1'b0;
    row_inc   = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_pending) begin
          op_ref_d  = 1'b1;
          ref_grant = 1'b1;
          state_d   = ST_SETUP;
        end else if (req_valid) begin
          op_ref_d  = 1'b0;
          op_addr_d = req_addr;
          op_wr_d   = req_write;
          op_data_d = req_wdata;
          state_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (op_ref_q) begin
          state_d = ST_REF;
          cnt_d   = CW'(T_RAS - 1);
        end else begin
          state_d = ST_ROW;
          cnt_d   = CW'(T_RCD - 1);
        end
      end
      ST_ROW: begin
        if (cnt_q == '0) begin
          state_d = ST_COL;
          cnt_d   = CW'(T_CAS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_COL: begin
        if (cnt_q == '0) begin
          done    = 1'b1;
          state_d = ST_PRE;
          cnt_d   = CW'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_REF: begin
        if (cnt_q == '0) begin
          row_inc = 1'b1;
          state_d = ST_PRE;
          cnt_d   = CW'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign col_phase  = (state_d == ST_COL);
  assign strobe_row = (state_d == ST_ROW) || (state_d == ST_COL) || (state_d == ST_REF);
  assign write_col  = col_phase && op_wr_d;

  drc_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .word_addr   (op_addr_d),
    .refresh_row (ref_row),
    .use_refresh (op_ref_d),
    .col_phase   (col_phase),
    .bus_addr    (mux_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_addr_q   <= '0;
      op_wr_q     <= 1'b0;
      op_ref_q    <= 1'b0;
      op_data_q   <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      req_ready   <= 1'b0;
      req_rdata   <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      op_addr_q   <= op_addr_d;
      op_wr_q     <= op_wr_d;
      op_ref_q    <= op_ref_d;
      op_data_q   <= op_data_d;
      dram_addr   <= mux_addr;
      dram_ras_n  <= !strobe_row;
      dram_cas_n  <= !col_phase;
      dram_we_n   <= !write_col;
      dram_dq_oe  <= write_col;
      dram_dq_out <= op_data_d;
      req_ready   <= done;
      if (done) req_rdata <= dram_dq_in;
    end
  end

  // precharge watch: cycles with both strobes high, saturating at T_RP
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= HW'(T_RP);
    end else if (dram_ras_n && dram_cas_n) begin
      if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  // R3: the column strobe only inside a row strobe
  assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R2: the column strobe never falls together with the row strobe
  assert_col_after_row_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> dram_cas_n);

  // R2: the row address is set up before the row strobe falls
  assert_row_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  // R4: a refresh cycle never asserts the column strobe
  assert_refresh_no_cas_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REF) |-> (dram_cas_n && !dram_ras_n));

  // R4: the refresh row advances by one after each refresh
  assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
    row_inc |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  // R6: a pending refresh wins in idle
  assert_refresh_first_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && ref_pending) |=> (state_q == ST_SETUP && op_ref_q));

  // R7: ready is a single-cycle pulse
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R8: precharge gap before every row strobe
  assert_precharge_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_RP)));

  // R9: grant only takes a pending request
  assert_grant_pending_R9: assert property (@(posedge clk) disable iff (rst)
    ref_grant |-> ref_pending);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROW_W        = 8,
  parameter int DATA_W       = 8,
  parameter int CLK_MHZ      = 200,
  parameter int REFRESH_MS   = 4,
  parameter int REF_INTERVAL = (REFRESH_MS * 1000 * CLK_MHZ) / (1 << ROW_W),
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2*ROW_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_ready,
  output logic [DATA_W-1:0]    req_rdata,
  output logic [ROW_W-1:0]     dram_addr,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic [DATA_W-1:0]    dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_W-1:0]    dram_dq_in,
  output logic                 refresh_overrun
);
  logic             ref_pending;
  logic             ref_grant;
  logic             row_inc;
  logic [ROW_W-1:0] ref_row;

  drc_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .grant   (ref_grant),
    .pending (ref_pending),
    .overrun (refresh_overrun)
  );

  drc_row_counter #(.ROW_W(ROW_W)) u_rowcnt (
    .clk (clk),
    .rst (rst),
    .inc (row_inc),
    .row (ref_row)
  );

  drc_sequencer #(
    .ROW_W (ROW_W), .DATA_W(DATA_W),
    .T_RCD (T_RCD), .T_CAS (T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_grant   (ref_grant),
    .row_inc     (row_inc),
    .req_ready   (req_ready),
    .req_rdata   (req_rdata),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in)
  );
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb;
  localparam int IVL   = 3125;   // 4 ms * 200 MHz / 256 rows
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_RP  = 2;
  localparam int LAT_IDLE = 2 + T_RCD + T_CAS;   // 6
  localparam int LAT_REF  = LAT_IDLE + 7;        // refresh: setup+3 ras+2 pre+idle

  // {write, addr[15:0], data[7:0]}
  localparam logic [24:0] VEC [10] = '{
    25'h1_1234_A5, 25'h1_3412_5A, 25'h1_0000_11, 25'h1_FFFF_EE,
    25'h0_1234_A5, 25'h0_3412_5A, 25'h0_0000_11, 25'h0_FFFF_EE,
    25'h1_1234_3C, 25'h0_1234_3C
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  req_rdata, dram_addr, dram_dq_out;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, refresh_overrun;
  logic [7:0]  dq_in = '0;

  logic        o_ready, o_ras_n, o_cas_n, o_we_n, o_oe, o_ovr;
  logic [7:0]  o_rdata, o_addr, o_dq;

  dram_refresh_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in), .refresh_overrun(refresh_overrun)
  );

  dram_refresh_ctrl #(.REF_INTERVAL(4)) u_dut_ovr (
    .clk(clk), .rst(rst), .req_valid(1'b0), .req_write(1'b0),
    .req_addr(16'h0000), .req_wdata(8'h00), .req_ready(o_ready),
    .req_rdata(o_rdata), .dram_addr(o_addr), .dram_ras_n(o_ras_n),
    .dram_cas_n(o_cas_n), .dram_we_n(o_we_n), .dram_dq_out(o_dq),
    .dram_dq_oe(o_oe), .dram_dq_in(8'h00), .refresh_overrun(o_ovr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- DRAM model, sampled 1 ns after each rising edge
  logic [7:0] mem [logic [15:0]];
  logic [7:0] m_row = '0, m_col = '0, exp_ref_row = '0;
  bit   prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0;
  int   ras_fall_cyc = 0, acc_stamp = 0, ref_cnt = 0, acc_cnt = 0;
  int   ref_stamp [16];
  int   ref_row_bad = 0, cas_wo_ras = 0, same_edge = 0, we_bad = 0;
  int   hi_run = 0, min_hi = 1000000;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        m_row = dram_addr;
        ras_fall_cyc = cyc;
        cas_seen = 1'b0;
        if (hi_run < min_hi) min_hi = hi_run;
        if (!dram_cas_n) same_edge++;
      end
      if (dram_ras_n && dram_cas_n) hi_run++; else hi_run = 0;
      if (prev_cas && !dram_cas_n) begin
        m_col = dram_addr;
        cas_seen = 1'b1;
        if (dram_ras_n) cas_wo_ras++;
        if (dram_we_n) dq_in = mem.exists({dram_addr, m_row}) ? mem[{dram_addr, m_row}] : 8'h00;
      end
      if (!dram_cas_n && !dram_we_n) begin
        if (!dram_dq_oe) we_bad++;
        mem[{m_col, m_row}] = dram_dq_out;
      end
      if (!dram_cas_n && dram_ras_n) cas_wo_ras++;
      if (!prev_ras && dram_ras_n) begin
        if (cas_seen) begin
          acc_cnt++;
          acc_stamp = ras_fall_cyc;
        end else begin
          if (m_row != exp_ref_row) ref_row_bad++;
          exp_ref_row = exp_ref_row + 8'd1;
          if (ref_cnt < 16) ref_stamp[ref_cnt] = ras_fall_cyc;
          ref_cnt++;
        end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  // ---------------- processor access, called at a falling edge
  task automatic do_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    lat = 0;
    @(negedge clk);
    lat = 1;
    chk(req_ready == 1'b0, "R7 ready low while waiting", {31'd0, req_ready}, 0);
    while (!req_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = req_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R7 ready single pulse", {31'd0, req_ready}, 0);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, cycle %0d expected end", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle",
        {29'd0, dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(!req_ready && !dram_dq_oe && !refresh_overrun, "R1 ready/oe/overrun low",
        {29'd0, req_ready, dram_dq_oe, refresh_overrun}, 0);
    chk(!o_ovr && o_ras_n, "R1 second instance reset", {30'd0, o_ovr, o_ras_n}, 1);

    // R5: no refresh before one full interval
    wait_cyc(IVL - 1);
    chk(ref_cnt == 0, "R5 no early refresh", ref_cnt, 0);

    // R6: request and refresh meet in idle: refresh first
    wait_cyc(IVL);
    do_access(1'b1, 16'hBEEF, 8'h77, rd, lat);
    chk(ref_cnt == 1, "R6 refresh ran", ref_cnt, 1);
    chk(ref_stamp[0] == IVL + 2, "R5 first refresh start", ref_stamp[0], IVL + 2);
    chk(ref_stamp[0] < acc_stamp, "R6 refresh before access", ref_stamp[0], acc_stamp);
    chk(lat == LAT_REF, "R6/R7 latency behind refresh", lat, LAT_REF);
    chk(mem.exists(16'hBEEF) && mem[16'hBEEF] == 8'h77, "R3 write stored",
        mem.exists(16'hBEEF) ? mem[16'hBEEF] : 8'hXX, 8'h77);
    chk(m_row == 8'hEF && m_col == 8'hBE, "R2 row/col split", {m_col, m_row}, 16'hBEEF);

    // vector table of writes and reads
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = VEC[i][23:8];
      d = VEC[i][7:0];
      do_access(VEC[i][24], a, d, rd, lat);
      chk(m_row == a[7:0], "R2 row half latched", m_row, a[7:0]);
      chk(m_col == a[15:8], "R2 column half latched", m_col, a[15:8]);
      if (VEC[i][24])
        chk(mem.exists(a) && mem[a] == d, "R3 write data at location",
            mem.exists(a) ? mem[a] : 8'hXX, d);
      else
        chk(rd == d, "R3 read data", rd, d);
    end

    // R5: periodic second refresh while idle
    wait_cyc(2 * IVL + 20);
    chk(ref_cnt == 2, "R5 second refresh count", ref_cnt, 2);
    chk(ref_stamp[1] == 2 * IVL + 2, "R5 second refresh start", ref_stamp[1], 2 * IVL + 2);

    // R9/R6: access starts just before the interval ends; refresh is kept and follows
    wait_cyc(3 * IVL - 2);
    do_access(1'b0, 16'h3412, 8'h00, rd, lat);
    chk(lat == LAT_IDLE, "R6 started access not delayed", lat, LAT_IDLE);
    chk(rd == 8'h5A, "R3 read across refresh", rd, 8'h5A);
    repeat (20) @(negedge clk);
    chk(ref_cnt == 3, "R9 pending refresh kept", ref_cnt, 3);
    chk(ref_stamp[2] > acc_stamp, "R6 refresh after access", ref_stamp[2], acc_stamp);
    chk(!refresh_overrun, "R9 no overrun when served", refresh_overrun, 0);

    // R7: idle access latency
    wait_cyc(4 * IVL + 100);
    do_access(1'b0, 16'hFFFF, 8'h00, rd, lat);
    chk(lat == LAT_IDLE, "R7 idle latency", lat, LAT_IDLE);
    chk(rd == 8'hEE, "R3 read far corner", rd, 8'hEE);

    // R4 row sequence, R8 precharge, R3 strobe rules
    wait_cyc(6 * IVL + 50);
    chk(ref_cnt == 6, "R5 refresh count after six intervals", ref_cnt, 6);
    chk(ref_row_bad == 0, "R4 refresh rows 0,1,2..", ref_row_bad, 0);
    chk(exp_ref_row == 8'd6, "R4 row counter advance", exp_ref_row, 6);
    chk(min_hi >= T_RP, "R8 precharge gap", min_hi, T_RP);
    chk(cas_wo_ras == 0, "R3 cas only inside ras", cas_wo_ras, 0);
    chk(same_edge == 0, "R2 cas not with ras fall", same_edge, 0);
    chk(we_bad == 0, "R3 data driven on write", we_bad, 0);
    chk(acc_cnt == 13, "R7 one access per request", acc_cnt, 13);
    chk(!refresh_overrun, "R9 main overrun clear", refresh_overrun, 0);
    chk(o_ovr == 1'b1, "R9 overrun on short interval", o_ovr, 1);
    chk(o_cas_n == 1'b1, "R4 refresh-only instance cas high", o_cas_n, 1);

    summary();
    $finish;
  end
endmodule